// File: doc/BRIEF.md
# Right-Only Barrel Shifter with Word, Mantissa, Half-Word and Double-Length Modes

The block shifts a 64-bit operand A, and for double-length work also a 64-bit companion B, by a count of up to 63 positions. Every shift runs on a single right-rotation network. A left request arrives as its distance minus one. The count stage ones-complements it into the equivalent right distance, and a zero-fill mask after the rotator turns a rotation into an end-off shift in either direction. The caller picks the rotate or end-off action and the direction. The shift can act on the whole word or on the floating-point mantissa only. Word length is a single 64-bit word, two independent 32-bit halves, or a 128-bit A:B pair.

Bit numbering in this brief follows the port vectors: index 63 is the most significant bit of A. Index 0 is the least significant bit, and a right shift moves bits toward index 0. A request is a one-cycle pulse on `goIn`. The count stage and the operands are captured at that edge, and the result is registered at the next edge. Two enable bits decide which parts of A may take the result. A part whose enable is clear passes its input value through unchanged.

Top module: `rshift_unit`

## Requirements
- R1: During and after a synchronous reset `aOut`, `bOut` and `errOut` are zero.
- R2: With `goIn` sampled high at one rising edge, all outputs take the new result at the following rising edge and at no other time. While no request is in flight the outputs hold.
- R3: `dirSel` = 00 rotates right: bits leaving index 0 re-enter at the top of the field. In 64-bit mode the count is `cntIn` modulo 64.
- R4: `dirSel` = 01 rotates left. A left shift by N is requested with `cntIn` = N-1, and the count stage ones-complements it. So `cntIn` = 0 gives the same result as a right rotation by 63.
- R5: `dirSel` = 10 is an end-off right shift and `dirSel` = 11 an end-off left shift, again with `cntIn` = N-1. Vacated positions fill with zeros.
- R6: With `mantOnly` set in 64-bit single-length mode, only the mantissa `aOut[47:0]` shifts or rotates, within its 48 bits. `aOut[63:48]` keeps its input value, and an end-off shift of 48 or more positions clears the mantissa.
- R7: With `mode32` set, `aOut[63:32]` (inner half) and `aOut[31:0]` (outer half) shift independently by `cntIn` modulo 32. Bit 5 of the count is ignored.
- R8: With `mode32` and `mantOnly` set, the 24-bit fields `aOut[47:24]` and `aOut[23:0]` shift independently and `aOut[63:48]` is kept. An end-off shift of 24 or more positions clears a field.
- R9: `dblLen` with an end-off code in 64-bit mode shifts the 128-bit value {A,B}, with A as the upper word. `mantOnly` has no effect there.
- R10: A `dblLen` request that has a rotate code or `mode32` set leaves `aOut` and `bOut` unchanged and sets `errOut`. `errOut` is cleared by the result of the next accepted request.
- R11: `enBits[1]` enables the inner half (or inner mantissa) and `enBits[0]` the outer one in 32-bit mode. In 64-bit and double-length modes the result is written only when both bits are set. A disabled part passes its input through.
- R12: In single-length modes `bOut` equals `bIn` of the same request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| goIn | input | 1 | Request strobe, one cycle per shift |
| cntIn | input | 6 | Shift count (right: N, left: N-1) |
| dirSel | input | 2 | 00 rotate right, 01 rotate left, 10 end-off right, 11 end-off left |
| mode32 | input | 1 | Two independent 32-bit halves |
| mantOnly | input | 1 | Shift the mantissa field(s) only |
| dblLen | input | 1 | Treat A:B as one 128-bit operand |
| enBits | input | 2 | Part enables: bit 1 inner, bit 0 outer |
| aIn | input | 64 | Operand A |
| bIn | input | 64 | Operand B (lower word in double length) |
| aOut | output | 64 | Registered result A |
| bOut | output | 64 | Registered result B |
| errOut | output | 1 | Last completed request was rejected |

## Verification
Each result lands on the second rising edge after the falling edge where the bench raises `goIn`. The first edge captures the count stage and the operands, and the second registers the result. The bench drops `goIn` at the next falling edge and compares `aOut`, `bOut` and `errOut` at the falling edge that follows the result edge. One explicit check samples between the two edges to confirm that the old value is still present, and idle cycles confirm that the outputs hold. Expected values come from shift-operator arithmetic on each field, swept over every count, every direction code and every mode.

// File: rtl/rshift_pkg.sv
package rshift_pkg;
  localparam int WORD_W  = 64;
  localparam int HALF_W  = WORD_W / 2;
  localparam int MANT_W  = 48;
  localparam int MANT_H  = MANT_W / 2;
  localparam int DBL_W   = 2 * WORD_W;
  localparam int CNT_W   = $clog2(WORD_W);
  localparam int IDX_W   = $clog2(DBL_W);

  typedef struct packed {
    logic             fire;
    logic             reject;
    logic             rotate;
    logic             left;
    logic             dbl;
    logic             mant;
    logic             half;
    logic [1:0]       en;
    logic [CNT_W-1:0] stored;
  } shiftCtl_t;

  // One field of width f, low-aligned in v. Right rotation, then zero mask.
  function automatic logic [DBL_W-1:0] laneShift(
    input logic [DBL_W-1:0] v,
    input int               f,
    input logic             rotate,
    input logic             left,
    input logic [CNT_W-1:0] stored,
    input int               wsz
  );
    int r;
    int n;
    int k;
    int idx;
    logic [DBL_W-1:0] rot;
    logic [DBL_W-1:0] res;
    r = int'(stored);
    n = wsz - r;
    if (rotate) k = left ? (f - (n % f)) % f : r % f;
    else if (left) k = (n >= f) ? 0 : f - n;
    else k = (r >= f) ? 0 : r;
    rot = '0;
    res = '0;
    for (int i = 0; i < DBL_W; i++) begin
      if (i < f) begin
        idx = i + k;
        if (idx >= f) idx = idx - f;
        rot[i] = v[idx[IDX_W-1:0]];
      end
    end
    for (int i = 0; i < DBL_W; i++) begin
      if (i < f) begin
        if (rotate) res[i] = rot[i];
        else if (left) res[i] = (n < f && i >= n) ? rot[i] : 1'b0;
        else res[i] = (r < f && i < f - r) ? rot[i] : 1'b0;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/rshift_ctrl.sv
module rshift_ctrl
  import rshift_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             goIn,
  input  logic [CNT_W-1:0] cntIn,
  input  logic [1:0]       dirSel,
  input  logic             mode32,
  input  logic             mantOnly,
  input  logic             dblLen,
  input  logic [1:0]       enBits,
  output shiftCtl_t        ctl
);
  logic [CNT_W-1:0] cntMasked;
  logic [CNT_W-1:0] cntStored;

  always_comb begin
    cntMasked = cntIn;
    if (mode32) cntMasked[CNT_W-1] = 1'b0;
    cntStored = dirSel[0] ? ~cntMasked : cntMasked;
    if (mode32) cntStored[CNT_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else begin
      ctl.fire <= goIn;
      if (goIn) begin
        ctl.reject <= dblLen & (mode32 | ~dirSel[1]);
        ctl.rotate <= ~dirSel[1];
        ctl.left   <= dirSel[0];
        ctl.dbl    <= dblLen;
        ctl.mant   <= mantOnly;
        ctl.half   <= mode32;
        ctl.en     <= enBits;
        ctl.stored <= cntStored;
      end
    end
  end
endmodule

// File: rtl/rshift_dp.sv
module rshift_dp
  import rshift_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  shiftCtl_t         ctl,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  output logic [WORD_W-1:0] aOut,
  output logic [WORD_W-1:0] bOut,
  output logic              errOut
);
  logic [WORD_W-1:0] aQ;
  logic [WORD_W-1:0] bQ;
  logic [WORD_W-1:0] aNext;
  logic [WORD_W-1:0] bNext;
  logic [DBL_W-1:0]  wideRes;
  logic [DBL_W-1:0]  laneRes;
  logic              laneOn;
  int                base;
  int                fw;
  int                wsz;

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ <= '0;
      bQ <= '0;
    end else if (capture) begin
      aQ <= aIn;
      bQ <= bIn;
    end
  end

  always_comb begin
    aNext   = aQ;
    bNext   = bQ;
    wideRes = '0;
    laneRes = '0;
    laneOn  = 1'b0;
    base    = 0;
    fw      = 0;
    wsz     = 0;
    if (ctl.dbl) begin
      wideRes = laneShift({aQ, bQ}, DBL_W, 1'b0, ctl.left, ctl.stored, WORD_W);
      if (&ctl.en) begin
        aNext = wideRes[DBL_W-1:WORD_W];
        bNext = wideRes[WORD_W-1:0];
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        laneOn  = ctl.half ? ctl.en[h] : ((h == 0) && (&ctl.en));
        wsz     = ctl.half ? HALF_W : WORD_W;
        fw      = ctl.half ? (ctl.mant ? MANT_H : HALF_W) : (ctl.mant ? MANT_W : WORD_W);
        base    = ctl.half ? h * fw : 0;
        laneRes = laneShift(DBL_W'(aQ >> base), fw, ctl.rotate, ctl.left, ctl.stored, wsz);
        for (int i = 0; i < WORD_W; i++) begin
          if (laneOn && i < fw) aNext[base + i] = laneRes[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aOut   <= '0;
      bOut   <= '0;
      errOut <= 1'b0;
    end else if (ctl.fire) begin
      if (ctl.reject) begin
        errOut <= 1'b1;
      end else begin
        aOut   <= aNext;
        bOut   <= bNext;
        errOut <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rshift_unit.sv
module rshift_unit
  import rshift_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              goIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [1:0]        dirSel,
  input  logic              mode32,
  input  logic              mantOnly,
  input  logic              dblLen,
  input  logic [1:0]        enBits,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  output logic [WORD_W-1:0] aOut,
  output logic [WORD_W-1:0] bOut,
  output logic              errOut
);
  shiftCtl_t ctl;

  rshift_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .goIn     (goIn),
    .cntIn    (cntIn),
    .dirSel   (dirSel),
    .mode32   (mode32),
    .mantOnly (mantOnly),
    .dblLen   (dblLen),
    .enBits   (enBits),
    .ctl      (ctl)
  );

  rshift_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .capture (goIn),
    .ctl     (ctl),
    .aIn     (aIn),
    .bIn     (bIn),
    .aOut    (aOut),
    .bOut    (bOut),
    .errOut  (errOut)
  );
endmodule

// File: rtl/rshift_chk.sv
module rshift_chk
  import rshift_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              goIn,
  input logic [CNT_W-1:0]  cntIn,
  input logic [1:0]        dirSel,
  input logic              mode32,
  input logic              mantOnly,
  input logic              dblLen,
  input logic [1:0]        enBits,
  input logic [WORD_W-1:0] aIn,
  input logic [WORD_W-1:0] bIn,
  input logic [WORD_W-1:0] aOut,
  input logic [WORD_W-1:0] bOut,
  input logic              errOut
);
  logic rejReq;
  logic goOk;
  assign rejReq = goIn && !rst && dblLen && (mode32 || !dirSel[1]);
  assign goOk   = goIn && !rst;

  // R2
  out_change_after_go_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ((aOut != $past(aOut)) || (bOut != $past(bOut)))) |-> $past(goOk, 2));

  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rejReq, 2)) |-> ($stable(aOut) && $stable(bOut)));

  // R10
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $rose(errOut)) |-> $past(rejReq, 2));

  // R12
  b_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(goOk && !dblLen, 2)) |-> (bOut == $past(bIn, 2)));

  // R6
  mant_keeps_exp_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(goOk && !dblLen && mantOnly && !mode32, 2))
      |-> (aOut[WORD_W-1:MANT_W] == $past(aIn[WORD_W-1:MANT_W], 2)));

  // R11
  wide_enable_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(goOk && !mode32 && !rejReq && (enBits != 2'b11), 2))
      |-> ((aOut == $past(aIn, 2)) && (bOut == $past(bIn, 2))));
endmodule

bind rshift_unit rshift_chk u_chk (.*);

// File: tb/rshift_unit_tb.sv
module rshift_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        goIn = 1'b0;
  logic [5:0]  cntIn = '0;
  logic [1:0]  dirSel = '0;
  logic        mode32 = 1'b0;
  logic        mantOnly = 1'b0;
  logic        dblLen = 1'b0;
  logic [1:0]  enBits = 2'b11;
  logic [63:0] aIn = '0;
  logic [63:0] bIn = '0;
  logic [63:0] aOut;
  logic [63:0] bOut;
  logic        errOut;

  int nChecks = 0;
  int nFail = 0;
  logic [63:0] expA = '0;
  logic [63:0] expB = '0;
  logic        expErr = 1'b0;

  always #5 clk = ~clk;

  rshift_unit u_dut (
    .clk(clk), .rst(rst), .goIn(goIn), .cntIn(cntIn), .dirSel(dirSel),
    .mode32(mode32), .mantOnly(mantOnly), .dblLen(dblLen), .enBits(enBits),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut), .errOut(errOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mLane(input logic [127:0] v, input int f,
                                          input bit rot, input bit left, input int r, input int n);
    logic [127:0] mask;
    int k;
    mask = (f >= 128) ? {128{1'b1}} : ((128'(1) << f) - 128'(1));
    v = v & mask;
    if (rot) begin
      k = left ? n % f : r % f;
      if (k == 0) return v;
      if (left) return ((v << k) | (v >> (f - k))) & mask;
      return ((v >> k) | (v << (f - k))) & mask;
    end
    if (left) return (n >= f) ? '0 : ((v << n) & mask);
    return (r >= f) ? '0 : (v >> r);
  endfunction

  task automatic model(input logic [5:0] c, input logic [1:0] d, input bit m32, input bit mant,
                       input bit dbl, input logic [1:0] en, input logic [63:0] a, input logic [63:0] b);
    logic [127:0] w;
    int wd;
    int r;
    int n;
    bit rot;
    bit left;
    wd = m32 ? 32 : 64;
    r = int'(c) % wd;
    n = r + 1;
    rot = !d[1];
    left = d[0];
    if (dbl && (m32 || rot)) begin
      expErr = 1'b1;
    end else begin
      expErr = 1'b0;
      expA = a;
      expB = b;
      if (dbl) begin
        if (en == 2'b11) begin
          w = mLane({a, b}, 128, 1'b0, left, r, n);
          expA = w[127:64];
          expB = w[63:0];
        end
      end else if (!m32) begin
        if (en == 2'b11) begin
          if (mant) begin
            w = mLane(128'(a[47:0]), 48, rot, left, r, n);
            expA[47:0] = w[47:0];
          end else begin
            w = mLane(128'(a), 64, rot, left, r, n);
            expA = w[63:0];
          end
        end
      end else begin
        if (en[1]) begin
          if (mant) begin
            w = mLane(128'(a[47:24]), 24, rot, left, r, n);
            expA[47:24] = w[23:0];
          end else begin
            w = mLane(128'(a[63:32]), 32, rot, left, r, n);
            expA[63:32] = w[31:0];
          end
        end
        if (en[0]) begin
          if (mant) begin
            w = mLane(128'(a[23:0]), 24, rot, left, r, n);
            expA[23:0] = w[23:0];
          end else begin
            w = mLane(128'(a[31:0]), 32, rot, left, r, n);
            expA[31:0] = w[31:0];
          end
        end
      end
    end
  endtask

  task automatic runOp(input string tag, input logic [5:0] c, input logic [1:0] d, input bit m32,
                       input bit mant, input bit dbl, input logic [1:0] en,
                       input logic [63:0] a, input logic [63:0] b);
    model(c, d, m32, mant, dbl, en, a, b);
    @(negedge clk);
    cntIn = c; dirSel = d; mode32 = m32; mantOnly = mant; dblLen = dbl;
    enBits = en; aIn = a; bIn = b; goIn = 1'b1;
    @(negedge clk);
    goIn = 1'b0;
    @(negedge clk);
    chk(tag, aOut, expA);
    chk(dbl ? tag : "R12", bOut, expB);
    chk("R10", 64'(errOut), 64'(expErr));
  endtask

  function automatic string tagFor(input logic [1:0] d, input bit m32, input bit mant, input bit dbl);
    if (dbl) return (m32 || !d[1]) ? "R10" : "R9";
    if (m32) return mant ? "R8" : "R7";
    if (mant) return "R6";
    if (d == 2'b00) return "R3";
    if (d == 2'b01) return "R4";
    return "R5";
  endfunction

  function automatic logic [63:0] pat(input int i, input int s);
    logic [63:0] x;
    x = {32'(i) * 32'h9E3779B9, ~(32'(i + s) * 32'h85EBCA6B)};
    return x ^ (64'(s) << 40) ^ 64'hC3A5_0F96_7E18_D24B;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [63:0] aPat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    chk("R1", aOut, 64'h0);
    chk("R1", bOut, 64'h0);
    chk("R1", 64'(errOut), 64'h0);

    // R2: latency and hold
    aPat = 64'h0123_4567_89AB_CDEF;
    model(6'd4, 2'b00, 1'b0, 1'b0, 1'b0, 2'b11, aPat, 64'h55);
    @(negedge clk);
    cntIn = 6'd4; dirSel = 2'b00; mode32 = 0; mantOnly = 0; dblLen = 0;
    enBits = 2'b11; aIn = aPat; bIn = 64'h55; goIn = 1'b1;
    @(negedge clk);
    goIn = 1'b0;
    chk("R2", aOut, 64'h0);
    @(negedge clk);
    chk("R2", aOut, 64'hF012_3456_789A_BCDE);
    aIn = '1; bIn = '1; cntIn = 6'd9;
    repeat (4) @(negedge clk);
    chk("R2", aOut, expA);
    chk("R2", bOut, expB);

    // R4: left by one equals right rotate by 63
    runOp("R4", 6'd0, 2'b01, 0, 0, 0, 2'b11, 64'h8000_0000_0000_0001, 64'h0);
    chk("R4", aOut, 64'h0000_0000_0000_0003);

    // full sweeps over directions, counts and modes
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 64; c++) begin
        for (int s = 0; s < 2; s++) begin
          for (int m = 0; m < 5; m++) begin
            bit m32;
            bit mant;
            bit dbl;
            m32  = (m == 2 || m == 3);
            mant = (m == 1 || m == 3);
            dbl  = (m == 4);
            runOp(tagFor(2'(d), m32, mant, dbl), 6'(c), 2'(d), m32, mant, dbl, 2'b11,
                  pat(c + 7 * d, s + m), pat(c + 3, s + 11));
          end
        end
      end
    end

    // R11: partial enables in every mode
    for (int en = 0; en < 3; en++) begin
      for (int d = 0; d < 4; d++) begin
        for (int m = 0; m < 5; m++) begin
          bit m32;
          bit mant;
          bit dbl;
          m32  = (m == 2 || m == 3);
          mant = (m == 1 || m == 3);
          dbl  = (m == 4);
          if (!(dbl && d < 2)) begin
            runOp("R11", 6'd5, 2'(d), m32, mant, dbl, 2'(en), pat(en + d, m), pat(d, en));
            runOp("R11", 6'd33, 2'(d), m32, mant, dbl, 2'(en), pat(m, d), pat(en, 3));
          end
        end
      end
    end

    // R10: rejection in 32-bit mode, then clearing by an accepted request
    runOp("R10", 6'd3, 2'b10, 1, 0, 1, 2'b11, 64'hDEAD_BEEF_0000_1111, 64'h1);
    runOp("R10", 6'd3, 2'b00, 0, 0, 1, 2'b11, 64'h1111_2222_3333_4444, 64'h2);
    runOp("R10", 6'd1, 2'b10, 0, 0, 0, 2'b11, 64'hF0F0_F0F0_F0F0_F0F0, 64'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule